// File: doc/BRIEF.md
# Serial-Bus Wiper Register Controller

This block is the digital front end of a single-channel digitally controlled potentiometer. It is a two-wire serial-bus (I2C) slave that owns one 7-bit volatile wiper register. SCL and SDA are sampled on a fast system clock. Each line passes through a two-flop synchronizer and a run-length debounce filter. START, repeated START and STOP are then detected from the filtered levels. The block matches a fixed 7-bit device identifier and accepts a single register address, 00h. It drives the shared SDA line only through an open-drain enable, which pulls the line low when set.

A write is: START, identifier with R/W=0, address, data, STOP. The data byte is committed the moment its last bit is clocked in. A read is: START, identifier with R/W=0, address, repeated START, identifier with R/W=1. After that the slave sends the wiper value once per byte for as long as the master acknowledges. The analog side uses `wiper` as the tap code and `wiper_upd` as a change strobe. Code 00h selects the tap nearest the low terminal and 7Fh the tap nearest the high terminal.

There is no stream interface. The bus itself paces every transfer, and the wiper outputs are plain level and strobe pins with no back-pressure.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset, `wiper` holds midscale (64), `sda_oe` is 0 (SDA released) and `wiper_upd` is 0.
- R2: A write of identifier 0101000 with R/W (first-byte LSB) = 0, address 00h and a data byte gets an ACK (SDA low in the ninth clock) after each of the three bytes. `wiper` then equals data bits 6:0, and data bit 7 has no effect.
- R3: `wiper` changes only at the SCL falling edge that ends the data LSB. It holds the old value while that bit's SCL is high and the new value before the ACK clock rises. `wiper_upd` is high for exactly one system clock per load.
- R4: A first byte whose upper seven bits differ from 0101000 gets no ACK, and `wiper` does not change.
- R5: An address byte other than 00h gets no ACK, and a data byte that follows it leaves `wiper` unchanged.
- R6: A read acknowledges the three command bytes. It then shifts out {0, wiper[6:0]} MSB first, with each bit driven while SCL is low.
- R7: Each master ACK after the eighth bit of a read byte starts another copy of the byte. A master NACK makes the slave release SDA for good until the next START.
- R8: A STOP in the middle of a data byte leaves `wiper` unchanged. A repeated START in the middle of a byte restarts identifier matching, and a full write that follows it succeeds.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_CYC system clocks has no effect on the transfer in progress.
- R10: The slave begins pulling SDA low only while the filtered SCL is low, and never drives SDA while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level from the pad |
| sda_i | input | 1 | Serial data level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wiper | output | WIPER_W | Current wiper tap code |
| wiper_upd | output | 1 | One-cycle strobe on every wiper load |

## Verification
The bench builds the block with its default parameters: FILT_CYC of 10 clocks, which is 50 ns at 200 MHz, identifier 0101000, address 00h and a 7-bit wiper. It uses a bus quarter-period of 16 clocks. That quarter-period is just above the synchronizer-plus-filter latency, so every slave response is checked close to the deadline at which the bus samples it. Glitches of 6 clocks stay under the filter length. This makes it possible to show that glitches on both lines in the middle of a byte are ignored, while real edges only 16 clocks apart still get through.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, // waiting for START
    ST_ID,   // receiving identifier byte
    ST_REG,  // receiving register address
    ST_DATA, // receiving write data
    ST_TX,   // sending read data
    ST_SKIP  // transaction rejected or done, wait for START/STOP
  } phase_t;
endpackage

// File: rtl/wiper_i2c_filt.sv
module wiper_i2c_filt #(
  parameter int FILT_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] != line_o) begin
        if (run_q == CW'(FILT_CYC - 1)) begin
          line_o <= sync_q[1];
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  // R9
  filt_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_o) |-> ($past(sync_q[1], 1) == line_o && $past(sync_q[1], 2) == line_o));
endmodule

// File: rtl/wiper_i2c_cond.sv
module wiper_i2c_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
  assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wiper_i2c_pkg::*;
#(
  parameter int          FILT_CYC = 10,
  parameter int          WIPER_W  = 7,
  parameter logic [6:0]  DEV_ID   = 7'b0101000,
  parameter logic [7:0]  REG_ADDR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [WIPER_W-1:0] wiper,
  output logic               wiper_upd
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [WIPER_W-1:0] MID_CODE = WIPER_W'(1 << (WIPER_W - 1));

  logic [1:0] raw_lines, flt_lines;
  logic       scl_f, sda_f, scl_rise, scl_fall, bus_start, bus_stop;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    wiper_i2c_filt #(.FILT_CYC(FILT_CYC)) i_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(flt_lines[g])
    );
  end

  assign scl_f = flt_lines[1];
  assign sda_f = flt_lines[0];

  wiper_i2c_cond i_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  phase_t            phase, after_ack;
  logic [CNT_W-1:0]  bit_cnt;
  logic              in_ack, mst_ack;
  logic [BYTE_W-1:0] rx_sh, tx_sh, tx_byte;

  assign tx_byte = BYTE_W'(wiper);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bit_cnt   <= '0;
      in_ack    <= 1'b0;
      mst_ack   <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      sda_oe    <= 1'b0;
      wiper     <= MID_CODE;
      wiper_upd <= 1'b0;
    end else begin
      wiper_upd <= 1'b0;
      if (bus_stop) begin
        phase   <= ST_IDLE;
        sda_oe  <= 1'b0;
        in_ack  <= 1'b0;
        bit_cnt <= '0;
      end else if (bus_start) begin
        phase   <= ST_ID;
        sda_oe  <= 1'b0;
        in_ack  <= 1'b0;
        bit_cnt <= '0;
      end else if (phase != ST_IDLE && phase != ST_SKIP) begin
        if (scl_rise) begin
          if (in_ack) begin
            mst_ack <= ~sda_f;
          end else if (bit_cnt != CNT_W'(BYTE_W)) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack  <= 1'b0;
            bit_cnt <= '0;
            if (phase == ST_TX && !mst_ack) begin
              phase  <= ST_SKIP;
              sda_oe <= 1'b0;
            end else if (phase == ST_TX || after_ack == ST_TX) begin
              phase   <= ST_TX;
              tx_sh   <= tx_byte;
              sda_oe  <= ~tx_byte[BYTE_W-1];
              mst_ack <= 1'b0;
            end else begin
              phase  <= after_ack;
              sda_oe <= 1'b0;
            end
          end else if (bit_cnt == CNT_W'(BYTE_W)) begin
            case (phase)
              ST_ID: begin
                if (rx_sh[BYTE_W-1:1] == DEV_ID) begin
                  sda_oe    <= 1'b1;
                  in_ack    <= 1'b1;
                  after_ack <= rx_sh[0] ? ST_TX : ST_REG;
                end else begin
                  phase <= ST_SKIP;
                end
              end
              ST_REG: begin
                if (rx_sh == REG_ADDR) begin
                  sda_oe    <= 1'b1;
                  in_ack    <= 1'b1;
                  after_ack <= ST_DATA;
                end else begin
                  phase <= ST_SKIP;
                end
              end
              ST_DATA: begin
                wiper     <= rx_sh[WIPER_W-1:0];
                wiper_upd <= 1'b1;
                sda_oe    <= 1'b1;
                in_ack    <= 1'b1;
                after_ack <= ST_SKIP;
              end
              default: begin
                sda_oe <= 1'b0;
                in_ack <= 1'b1;
              end
            endcase
          end else if (phase == ST_TX) begin
            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~tx_sh[BYTE_W-2];
          end
        end
      end
    end
  end

  // R3
  wiper_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> wiper_upd);
  // R3
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_upd |=> !wiper_upd);
  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_IDLE || phase == ST_SKIP) |-> !sda_oe);
endmodule

// File: tb/test_wiper_i2c_slave.sv
module test_wiper_i2c_slave;
  localparam int Q = 16;
  localparam int G = 6;
  localparam logic [6:0] ID = 7'b0101000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wiper_upd;
  logic [6:0] wiper;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, upd_seen = 0, upd_exp = 0;
  logic [6:0] exp_w;

  always #2.5 clk = ~clk;

  wiper_i2c_slave i_wiper_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wiper(wiper), .wiper_upd(wiper_upd)
  );

  always @(posedge clk) if (rst_n && wiper_upd) upd_seen++;

  function automatic logic [7:0] read_byte(input logic [6:0] w);
    return {1'b0, w};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, input int nbits,
                           output bit ack, output logic [6:0] pre8, output logic [6:0] post8);
    for (int i = 7; i >= 8 - nbits; i--) begin
      sda_m = b[i];
      if (glitch && i == 3) begin
        repeat (4) @(negedge clk); scl_m = 1'b1; repeat (G) @(negedge clk);
        scl_m = 1'b0; repeat (Q - 4 - G) @(negedge clk);
      end else q();
      scl_m = 1'b1; q();
      if (i == 0) pre8 = wiper;
      if (glitch && i == 3) begin
        sda_m = ~b[i]; repeat (G) @(negedge clk); sda_m = b[i];
      end
      q(); scl_m = 1'b0; q();
    end
    post8 = wiper;
    ack = 1'b0;
    if (nbits < 8) return;
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ack = ~sda_line;
    q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit drive_ok);
    drive_ok = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q();
      if (scl_m != 1'b0) drive_ok = 1'b0;
      scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
    end
    q();
    sda_m = ~give_ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] id, input logic [7:0] addr, input logic [7:0] data,
                          input bit glitch, input string tag);
    bit a1, a2, a3;
    logic [6:0] p0, p1;
    bit id_ok, addr_ok;
    id_ok = (id == ID);
    addr_ok = (addr == 8'h00);
    bus_start();
    send_byte({id, 1'b0}, 1'b0, 8, a1, p0, p1);
    check(a1 == id_ok, {tag, " R4 id ack"}, a1, id_ok);
    if (a1) begin
      send_byte(addr, 1'b0, 8, a2, p0, p1);
      check(a2 == addr_ok, {tag, " R5 addr ack"}, a2, addr_ok);
      send_byte(data, glitch, 8, a3, p0, p1);
      if (a2) begin
        check(a3 == 1'b1, {tag, " R2 data ack"}, a3, 1);
        check(p0 == exp_w, {tag, " R3 old value held during LSB"}, p0, exp_w);
        exp_w = data[6:0];
        upd_exp++;
        check(p1 == exp_w, {tag, " R3 new value at LSB fall"}, p1, exp_w);
      end else begin
        check(a3 == 1'b0, {tag, " R5 data after bad addr no ack"}, a3, 0);
      end
    end
    bus_stop();
    check(wiper == exp_w, {tag, " R2 wiper value"}, wiper, exp_w);
    check(sda_oe == 1'b0, {tag, " R10 released when idle"}, sda_oe, 0);
  endtask

  task automatic do_read(input int n, input string tag);
    bit a1, a2, a3, dok;
    logic [6:0] p0, p1;
    logic [7:0] b;
    bus_start();
    send_byte({ID, 1'b0}, 1'b0, 8, a1, p0, p1);
    send_byte(8'h00, 1'b0, 8, a2, p0, p1);
    bus_start();
    send_byte({ID, 1'b1}, 1'b0, 8, a3, p0, p1);
    check(a1 && a2 && a3, {tag, " R6 command acks"}, {a1, a2, a3}, 3'b111);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b, dok);
      check(b == read_byte(exp_w), {tag, " R7 R6 read byte"}, b, read_byte(exp_w));
    end
    check(sda_oe == 1'b0, {tag, " R7 released after NACK"}, sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    logic [6:0] p0, p1, rid;
    logic [7:0] rd, ra;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R1 reset state
    check(wiper == 7'd64, "R1 wiper midscale", wiper, 64);
    check(sda_oe == 1'b0, "R1 SDA released", sda_oe, 0);
    check(wiper_upd == 1'b0, "R1 no strobe", wiper_upd, 0);
    rst_n = 1'b1;
    exp_w = 7'd64;
    q(); q();

    // R2: bit 7 ignored
    do_write(ID, 8'h00, 8'hD5, 1'b0, "R2 msb set");
    do_write(ID, 8'h00, 8'h00, 1'b0, "R2 zero");
    do_write(ID, 8'h00, 8'h7F, 1'b0, "R2 full");
    // R4 / R5
    do_write(7'b0101001, 8'h00, 8'h11, 1'b0, "R4 wrong id");
    do_write(ID, 8'h01, 8'h22, 1'b0, "R5 wrong addr");
    do_write(ID, 8'h80, 8'h33, 1'b0, "R5 high addr");
    // R9 glitches in the data byte
    do_write(ID, 8'h00, 8'h5A, 1'b1, "R9 glitch");
    // R6 / R7
    do_read(1, "R6 single");
    do_read(3, "R7 stream");

    // R8: STOP mid data byte
    bus_start();
    send_byte({ID, 1'b0}, 1'b0, 8, a, p0, p1);
    send_byte(8'h00, 1'b0, 8, a, p0, p1);
    send_byte(8'h0F, 1'b0, 4, a, p0, p1);
    bus_stop();
    check(wiper == exp_w, "R8 stop aborts data", wiper, exp_w);
    // R8: repeated START mid identifier byte
    bus_start();
    send_byte({ID, 1'b0}, 1'b0, 3, a, p0, p1);
    bus_start();
    send_byte({ID, 1'b0}, 1'b0, 8, a, p0, p1);
    check(a == 1'b1, "R8 restart id ack", a, 1);
    send_byte(8'h00, 1'b0, 8, a, p0, p1);
    send_byte(8'h19, 1'b0, 8, a, p0, p1);
    exp_w = 7'h19;
    upd_exp++;
    bus_stop();
    check(wiper == exp_w, "R8 write after restart", wiper, exp_w);

    // random mix
    for (int it = 0; it < 12; it++) begin
      int kind;
      kind = $urandom % 4;
      rd = 8'($urandom);
      if (kind == 0) do_write(ID, 8'h00, rd, 1'b0, "R2 random write");
      else if (kind == 1) begin
        rid = 7'($urandom);
        if (rid == ID) rid = rid ^ 7'h01;
        do_write(rid, 8'h00, rd, 1'b0, "R4 random id");
      end else if (kind == 2) begin
        ra = 8'($urandom);
        if (ra == 8'h00) ra = 8'h40;
        do_write(ID, ra, rd, 1'b0, "R5 random addr");
      end else do_read(1 + ($urandom % 2), "R7 random read");
    end

    check(upd_seen == upd_exp, "R3 one strobe per load", upd_seen, upd_exp);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule